// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Deadtime

This controller sits between two logic commands, one for the upper switch and one for the lower switch of a half-bridge, and the two gate-enable signals that drive them. Each gate-enable is a non-inverted, registered copy of its own command once the command has crossed a two-flop synchronizer. The controller prevents both switches from conducting at once. If both commands are high, both gates are held off. After either gate turns off, the opposite gate is held off for a fixed number of clock cycles.

Two supply-status flags, already in digital form, gate the outputs. A low-side supply undervoltage flag forces both gates off. A floating-supply undervoltage flag forces only the upper gate off. A bootstrap-charge enable follows the lower gate, so the floating supply capacitor charges only while the lower switch conducts. The deadtime length is the parameter `DEAD_CYC`, which defaults to 32 cycles (320 ns at 100 MHz).

Top module: `hb_gate_ctrl`

## Requirements
- R1: With the other command low and no flag set, each gate follows its own command at the same polarity, three clock edges after the command changes: two synchronizer stages plus one output register.
- R2: While both synchronized commands are high, both gates are low from the next edge on.
- R3: The two gates are never high in the same cycle.
- R4: After a gate falls, the opposite gate rises no earlier than `DEAD_CYC` edges later. With a steady request, it rises exactly `DEAD_CYC` edges after the fall.
- R5: While `lo_supply_uv` is high, both gates are low from the next edge on. Once the flag clears, a gate whose request is still valid returns on the next edge.
- R6: While `hi_supply_uv` is high, the upper gate is low from the next edge on. The lower gate is not affected.
- R7: `boot_chg` equals `lo_gate` in every cycle.
- R8: A synchronous active-high `rst` clears both gates, `boot_chg` and the synchronizers, and leaves the deadtime already elapsed. The first turn-on after reset therefore takes only the three-edge latency.
- R9: A request for the opposite gate that drops during a running deadtime is discarded. It does not restart or lengthen the count, so a later request is served at the original expiry.
- R10: A gate that turned off may turn on again without waiting for the deadtime, as long as the opposite gate has not switched in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | 1 | Upper switch command (asynchronous, low when idle) |
| lo_cmd | input | 1 | Lower switch command (asynchronous, low when idle) |
| lo_supply_uv | input | 1 | Low-side supply undervoltage flag, synchronous |
| hi_supply_uv | input | 1 | Floating supply undervoltage flag, synchronous |
| hi_gate | output | 1 | Upper gate enable |
| lo_gate | output | 1 | Lower gate enable |
| boot_chg | output | 1 | Bootstrap-charge enable |

## Verification
Command changes reach a gate on the third rising edge: a gate turning off is due on that third edge, and a gate turning on from the opposite side is due `DEAD_CYC` edges after the opposite gate falls, so 3 + `DEAD_CYC` edges after the input change. The supply flags act on the very next edge. The bench changes inputs on a falling edge and samples on a later falling edge. Every timed check looks once on the last cycle before the due edge, where the old value must still hold, and once right after it, where the new value must appear. This catches a result that arrives one edge early or one edge late.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic {
        SIDE_HI = 1'b0,
        SIDE_LO = 1'b1
    } side_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } pair_t;

    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_DEAD_CYC    = 32;

    // Which side may conduct given the commands and supply flags alone.
    function automatic pair_t resolve_request(pair_t cmd, logic uv_lo, logic uv_hi);
        pair_t r;
        r.hi = cmd.hi & ~cmd.lo & ~uv_lo & ~uv_hi;
        r.lo = cmd.lo & ~cmd.hi & ~uv_lo;
        return r;
    endfunction

    // Next state of one gate: hold if on, start only when the other is off
    // and either the gap has elapsed or this side was the last to turn off.
    function automatic logic gate_next(logic want, logic own_on, logic other_on,
                                       logic gap_done, logic self_last);
        return want & (own_on | (~other_on & (gap_done | self_last)));
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

    // R8: the synchronizer is empty one edge after reset.
    p_sync_clear_r8: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/hb_gap_timer.sv
module hb_gap_timer #(
    parameter int unsigned DEAD_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int unsigned   CW   = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (start)        cnt <= LOAD;
        else if (cnt != '0)    cnt <= cnt - ONE;
    end

    assign done = (cnt == '0);

    // R4: a running gap only shrinks until restarted.
    p_gap_shrinks_r4: assert property (@(posedge clk) disable iff (rst)
        (!done && !start) |=> (cnt < $past(cnt)));
    // R8: reset leaves the gap elapsed.
    p_gap_reset_r8: assert property (@(posedge clk) rst |=> done);
endmodule

// File: rtl/hb_gate_core.sv
module hb_gate_core
    import hb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t cmd,
    input  logic  uv_lo,
    input  logic  uv_hi,
    input  logic  gap_done,
    output pair_t gate,
    output logic  boot,
    output logic  gap_start
);
    pair_t want;
    pair_t nxt;
    pair_t gate_q;
    logic  boot_q;
    side_e last_q;
    logic  fell_hi;
    logic  fell_lo;

    always_comb begin
        want   = resolve_request(cmd, uv_lo, uv_hi);
        nxt.hi = gate_next(want.hi, gate_q.hi, gate_q.lo, gap_done, last_q == SIDE_HI);
        nxt.lo = gate_next(want.lo, gate_q.lo, gate_q.hi, gap_done, last_q == SIDE_LO);
        fell_hi   = gate_q.hi & ~nxt.hi;
        fell_lo   = gate_q.lo & ~nxt.lo;
        gap_start = fell_hi | fell_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            boot_q <= 1'b0;
            last_q <= SIDE_HI;
        end else begin
            gate_q <= nxt;
            boot_q <= nxt.lo;
            if (fell_hi)      last_q <= SIDE_HI;
            else if (fell_lo) last_q <= SIDE_LO;
        end
    end

    assign gate = gate_q;
    assign boot = boot_q;

    // R2: both commands high forces both gates off.
    p_both_off_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd.hi && cmd.lo) |=> (!gate_q.hi && !gate_q.lo));
    // R3: never both on.
    p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(gate_q.hi && gate_q.lo));
    // R5: low-side supply fault clears both gates.
    p_uv_lo_r5: assert property (@(posedge clk) disable iff (rst)
        uv_lo |=> (!gate_q.hi && !gate_q.lo));
    // R6: floating supply fault clears the upper gate.
    p_uv_hi_r6: assert property (@(posedge clk) disable iff (rst)
        uv_hi |=> !gate_q.hi);
    // R7: charge enable tracks the lower gate.
    p_boot_track_r7: assert property (@(posedge clk) disable iff (rst)
        boot_q == gate_q.lo);
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_pkg::*;
#(
    parameter int unsigned DEAD_CYC    = DEF_DEAD_CYC,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic lo_supply_uv,
    input  logic hi_supply_uv,
    output logic hi_gate,
    output logic lo_gate,
    output logic boot_chg
);
    localparam int unsigned MW = $clog2(DEAD_CYC + 1);
    localparam logic [MW-1:0] MAXV = MW'(DEAD_CYC);
    localparam logic [MW-1:0] ONE  = MW'(1);

    logic [1:0] cmd_sync;
    pair_t      cmd_s;
    pair_t      gate_s;
    logic       gap_done;
    logic       gap_start;

    hb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({hi_cmd, lo_cmd}),
        .q   (cmd_sync)
    );

    assign cmd_s.hi = cmd_sync[1];
    assign cmd_s.lo = cmd_sync[0];

    hb_gap_timer #(.DEAD_CYC(DEAD_CYC)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .start (gap_start),
        .done  (gap_done)
    );

    hb_gate_core u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd_s),
        .uv_lo     (lo_supply_uv),
        .uv_hi     (hi_supply_uv),
        .gap_done  (gap_done),
        .gate      (gate_s),
        .boot      (boot_chg),
        .gap_start (gap_start)
    );

    assign hi_gate = gate_s.hi;
    assign lo_gate = gate_s.lo;

    // Independent off-time counters used only by the deadtime checks.
    logic [MW-1:0] off_lo_cyc;
    logic [MW-1:0] off_hi_cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_lo_cyc <= MAXV;
            off_hi_cyc <= MAXV;
        end else begin
            if (lo_gate)                 off_lo_cyc <= '0;
            else if (off_lo_cyc != MAXV) off_lo_cyc <= off_lo_cyc + ONE;
            if (hi_gate)                 off_hi_cyc <= '0;
            else if (off_hi_cyc != MAXV) off_hi_cyc <= off_hi_cyc + ONE;
        end
    end

    // R4: opposite gate waits the full gap in both directions.
    p_gap_lo2hi_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_gate) |-> (off_lo_cyc >= MAXV));
    p_gap_hi2lo_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_gate) |-> (off_hi_cyc >= MAXV));
endmodule

// File: tb/sim_hb_gate_ctrl.sv
module sim_hb_gate_ctrl;
    localparam int DT = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi_cmd = 1'b0;
    logic lo_cmd = 1'b0;
    logic lo_supply_uv = 1'b0;
    logic hi_supply_uv = 1'b0;
    logic hi_gate, lo_gate, boot_chg;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic overlap_seen = 1'b0;

    always #4 clk = ~clk;

    hb_gate_ctrl #(.DEAD_CYC(DT)) u0 (
        .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .lo_supply_uv(lo_supply_uv), .hi_supply_uv(hi_supply_uv),
        .hi_gate(hi_gate), .lo_gate(lo_gate), .boot_chg(boot_chg)
    );

    always @(negedge clk) if (hi_gate && lo_gate) overlap_seen = 1'b1;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic t_reset;
        tick(3);
        check("R8 hi after reset", hi_gate, 1'b0);
        check("R8 lo after reset", lo_gate, 1'b0);
        check("R8 boot after reset", boot_chg, 1'b0);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_follow;
        hi_cmd = 1'b1;
        tick(2);
        check("R1 hi not yet on", hi_gate, 1'b0);
        tick(1);
        check("R1/R8 hi on at third edge", hi_gate, 1'b1);
    endtask

    task automatic t_gap_hi_to_lo;
        hi_cmd = 1'b0; lo_cmd = 1'b1;
        tick(2);
        check("R1 hi still on", hi_gate, 1'b1);
        tick(1);
        check("R1 hi off", hi_gate, 1'b0);
        tick(DT - 1);
        check("R4 lo held in gap", lo_gate, 1'b0);
        tick(1);
        check("R4 lo on after gap", lo_gate, 1'b1);
        check("R7 boot on with lo", boot_chg, 1'b1);
    endtask

    task automatic t_gap_lo_to_hi;
        lo_cmd = 1'b0; hi_cmd = 1'b1;
        tick(3);
        check("R1 lo off", lo_gate, 1'b0);
        check("R7 boot off with lo", boot_chg, 1'b0);
        tick(DT - 1);
        check("R4 hi held in gap", hi_gate, 1'b0);
        tick(1);
        check("R4 hi on after gap", hi_gate, 1'b1);
    endtask

    task automatic t_both;
        lo_cmd = 1'b1;
        tick(2);
        check("R2 hi before both seen", hi_gate, 1'b1);
        tick(1);
        check("R2 hi off with both", hi_gate, 1'b0);
        check("R2 lo off with both", lo_gate, 1'b0);
        tick(5);
        check("R2 lo still off", lo_gate, 1'b0);
        hi_cmd = 1'b0; lo_cmd = 1'b0;
        tick(DT + 5);
    endtask

    task automatic t_same_and_cancel;
        lo_cmd = 1'b1;
        tick(3);
        check("R1 lo on", lo_gate, 1'b1);
        lo_cmd = 1'b0;
        tick(3);
        check("R10 lo off", lo_gate, 1'b0);
        lo_cmd = 1'b1;
        tick(3);
        check("R10 lo back on inside gap", lo_gate, 1'b1);
        lo_cmd = 1'b0;
        tick(3);
        check("R9 lo off starts gap", lo_gate, 1'b0);
        hi_cmd = 1'b1;
        tick(2);
        hi_cmd = 1'b0;
        tick(6);
        check("R9 short request ignored", hi_gate, 1'b0);
        tick(DT - 11);
        hi_cmd = 1'b1;
        tick(2);
        check("R9 hi not before expiry", hi_gate, 1'b0);
        tick(1);
        check("R9 hi at original expiry", hi_gate, 1'b1);
    endtask

    task automatic t_uv_lo;
        lo_supply_uv = 1'b1;
        tick(1);
        check("R5 hi off on low fault", hi_gate, 1'b0);
        check("R5 lo off on low fault", lo_gate, 1'b0);
        tick(3);
        check("R5 hi held off", hi_gate, 1'b0);
        lo_supply_uv = 1'b0;
        tick(1);
        check("R5 hi returns", hi_gate, 1'b1);
    endtask

    task automatic t_uv_hi;
        hi_cmd = 1'b0; lo_cmd = 1'b1;
        tick(DT + 5);
        check("R1 lo on for fault test", lo_gate, 1'b1);
        hi_supply_uv = 1'b1;
        tick(2);
        check("R6 lo unaffected", lo_gate, 1'b1);
        check("R7 boot follows lo", boot_chg, 1'b1);
        lo_cmd = 1'b0; hi_cmd = 1'b1;
        tick(DT + 5);
        check("R6 hi held off", hi_gate, 1'b0);
        hi_supply_uv = 1'b0;
        tick(1);
        check("R6 hi on after clear", hi_gate, 1'b1);
    endtask

    initial begin
        t_reset();
        t_follow();
        t_gap_hi_to_lo();
        t_gap_lo_to_hi();
        t_both();
        t_same_and_cancel();
        t_uv_lo();
        t_uv_hi();
        check("R3 no overlap seen", overlap_seen, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule